// File: doc/BRIEF.md
# Clock Generator Mode and Output-Gating Core

This block is the digital control core of a clock generator. It runs on the 66 MHz seed clock. A three-bit select code picks how each output group behaves: it runs, it is held low, or it is put in high impedance. The block divides the seed clock by two to make the PCI-rate clocks, with no other timing element in that path. Each PCI output is gated by its own serial enable bit. An active-low bank-stop input holds a fixed group of those outputs low. Every gating change takes effect only while the divided clock is low, so an output never produces a shortened pulse.

Two of the device pins are shared. They are read as swing-select straps on the first clock edge after reset and then turn into reference-clock outputs. Until that capture is done, every output stays undriven (high impedance). The host-rate, reference, 66 MHz and memory-reference outputs are modelled as run and high-impedance control signals for the analog drivers. The PCI outputs are modelled as real divided clocks.

Top module: `clkctl_core`

## Requirements
- R1: While running and enabled, each PCI output is high for exactly one seed cycle and low for the next, which divides the seed clock by two.
- R2: On the first rising clock edge after reset is released, `strap_valid` goes to 1 and `mult_sel` takes the value of `strap_in`. After that, `mult_sel` never changes until the next reset.
- R3: During reset and until the strap capture is done, `out_hiz` is 1 and `host_run`, `aux_run` and `pci_clk` are all 0.
- R4: Select code {sel_rate,sel_a,sel_b} = 000 runs everything at the 100 MHz host rate: `host_run`=1, `host_fast`=0, `aux_run`=all ones, `out_hiz`=0. The reserved codes 010, 101 and 110 give the same result.
- R5: Code 100 runs everything with `host_fast`=1. Code 111 does the same and also sets `test_mode`=1. Every other code gives `test_mode`=0.
- R6: Code 001 keeps `host_run`=1 with `host_fast`=0 and keeps the PCI outputs running. It holds all `aux_run` bits at 0 (reference, 66 MHz and memory-reference outputs held low) with `out_hiz`=0.
- R7: Code 011 sets `out_hiz`=1, `host_run`=0, `aux_run`=0 and all `pci_clk` bits to 0.
- R8: While `bank_stop_n`=0, the STOP_COUNT PCI outputs at the highest indices are held low and the others keep running.
- R9: A PCI output whose `pci_en` bit is 0 stays low.
- R10: Gating changes take effect only on the edge where the divided clock falls. No PCI output is ever high on two consecutive cycles.
- R11: `host_run`, `host_fast`, `test_mode`, `aux_run` and `out_hiz` follow a new select code one clock edge after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 66 MHz seed clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_rate | input | 1 | Select bit 2 (host-rate select) |
| sel_a | input | 1 | Select bit 1 |
| sel_b | input | 1 | Select bit 0 |
| bank_stop_n | input | 1 | Active-low stop for the upper PCI group |
| pci_en | input | NUM_PCI | Per-output PCI enable bits |
| strap_in | input | STRAP_W | Swing-select straps read from the shared pins |
| mult_sel | output | STRAP_W | Latched swing-select value |
| strap_valid | output | 1 | Strap capture done; shared pins now drive outputs |
| out_hiz | output | 1 | All outputs in high impedance |
| host_run | output | 1 | Host clock pairs run |
| host_fast | output | 1 | Host rate 133 MHz when 1, 100 MHz when 0 |
| test_mode | output | 1 | Test mode selected |
| aux_run | output | 3 | Run controls: bit0 reference, bit1 66 MHz, bit2 memory-reference pair |
| pci_clk | output | NUM_PCI | Gated PCI-rate clocks |

## Verification
The bench builds the core with six PCI outputs and a stop group of four, with the group at the high indices. This leaves two outputs that keep running under bank-stop, and shows the group boundary away from the default values. With six outputs, every enable pattern the stimulus uses, including an enable toggled every cycle against the divider phase, can be compared bit by bit against the reference model within a few hundred cycles. The strap value is changed after capture, which shows that the latch ignores later pin activity.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

   localparam int AUX_N    = 3;
   localparam int AUX_REF  = 0;
   localparam int AUX_66   = 1;
   localparam int AUX_MREF = 2;

   typedef enum logic [2:0] {
      SEL_RUN100   = 3'b000,
      SEL_HOLD_AUX = 3'b001,
      SEL_RSV2     = 3'b010,
      SEL_ALL_HIZ  = 3'b011,
      SEL_RUN133   = 3'b100,
      SEL_RSV5     = 3'b101,
      SEL_RSV6     = 3'b110,
      SEL_TEST     = 3'b111
   } sel_code_e;

   typedef struct packed {
      logic hiz;
      logic host_run;
      logic host_fast;
      logic test;
      logic aux_run;
      logic pci_allow;
   } mode_t;

   function automatic mode_t decode_sel(input logic [2:0] code);
      mode_t m;
      m = '{hiz: 1'b0, host_run: 1'b1, host_fast: 1'b0, test: 1'b0,
            aux_run: 1'b1, pci_allow: 1'b1};
      case (sel_code_e'(code))
         SEL_HOLD_AUX: m.aux_run = 1'b0;
         SEL_ALL_HIZ: begin
            m.hiz       = 1'b1;
            m.host_run  = 1'b0;
            m.aux_run   = 1'b0;
            m.pci_allow = 1'b0;
         end
         SEL_RUN133: m.host_fast = 1'b1;
         SEL_TEST: begin
            m.host_fast = 1'b1;
            m.test      = 1'b1;
         end
         default: ;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/clkctl_strap_latch.sv
module clkctl_strap_latch #(
   parameter int STRAP_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STRAP_W-1:0] strap_in,
   output logic [STRAP_W-1:0] strap_q,
   output logic               done
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strap_q <= '0;
         done    <= 1'b0;
      end else if (!done) begin
         strap_q <= strap_in;
         done    <= 1'b1;
      end
   end

endmodule

// File: rtl/clkctl_mode_reg.sv
module clkctl_mode_reg
   import clkctl_pkg::*;
#(
   parameter int AUX_W = AUX_N
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done,
   input  mode_t            mode_now,
   output logic             hiz,
   output logic             host_run,
   output logic             host_fast,
   output logic             test,
   output logic [AUX_W-1:0] aux_run
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hiz       <= 1'b1;
         host_run  <= 1'b0;
         host_fast <= 1'b0;
         test      <= 1'b0;
         aux_run   <= '0;
      end else begin
         hiz       <= !done || mode_now.hiz;
         host_run  <= done && mode_now.host_run;
         host_fast <= done && mode_now.host_fast;
         test      <= done && mode_now.test;
         aux_run   <= {AUX_W{done && mode_now.aux_run}};
      end
   end

endmodule

// File: rtl/clkctl_pci_gate.sv
module clkctl_pci_gate #(
   parameter int NUM_PCI    = 8,
   parameter int STOP_COUNT = 5,
   parameter bit STOP_TOP   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               allow,
   input  logic               hiz,
   input  logic               bank_stop_n,
   input  logic [NUM_PCI-1:0] pci_en,
   output logic [NUM_PCI-1:0] pci_clk
);

   localparam int FIRST_STOP = STOP_TOP ? NUM_PCI - STOP_COUNT : 0;
   localparam int LAST_STOP  = STOP_TOP ? NUM_PCI - 1 : STOP_COUNT - 1;

   logic half_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) half_q <= 1'b0;
      else        half_q <= !half_q;
   end

   for (genvar i = 0; i < NUM_PCI; i++) begin : g_out
      localparam bit IN_GROUP = (i >= FIRST_STOP) && (i <= LAST_STOP);
      logic want;
      logic gate_q;

      if (IN_GROUP) begin : g_stoppable
         assign want = allow && pci_en[i] && bank_stop_n;
      end else begin : g_free
         assign want = allow && pci_en[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      gate_q <= 1'b0;
         else if (half_q) gate_q <= want;
      end

      assign pci_clk[i] = half_q && gate_q && !hiz;
   end

endmodule

// File: rtl/clkctl_core.sv
module clkctl_core
   import clkctl_pkg::*;
#(
   parameter int NUM_PCI    = 8,
   parameter int STOP_COUNT = 5,
   parameter bit STOP_TOP   = 1'b1,
   parameter int STRAP_W    = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel_rate,
   input  logic               sel_a,
   input  logic               sel_b,
   input  logic               bank_stop_n,
   input  logic [NUM_PCI-1:0] pci_en,
   input  logic [STRAP_W-1:0] strap_in,
   output logic [STRAP_W-1:0] mult_sel,
   output logic               strap_valid,
   output logic               out_hiz,
   output logic               host_run,
   output logic               host_fast,
   output logic               test_mode,
   output logic [AUX_N-1:0]   aux_run,
   output logic [NUM_PCI-1:0] pci_clk
);

   if (NUM_PCI < 1) begin : g_bad_pci
      $error("NUM_PCI must be at least 1");
   end
   if (STOP_COUNT < 0 || STOP_COUNT > NUM_PCI) begin : g_bad_stop
      $error("STOP_COUNT must lie between 0 and NUM_PCI");
   end
   if (STRAP_W < 1) begin : g_bad_strap
      $error("STRAP_W must be at least 1");
   end

   logic  done;
   mode_t mode_now;

   assign mode_now = decode_sel({sel_rate, sel_a, sel_b});

   clkctl_strap_latch #(.STRAP_W(STRAP_W)) u_strap (
      .clk      (clk),
      .rst_n    (rst_n),
      .strap_in (strap_in),
      .strap_q  (mult_sel),
      .done     (done)
   );

   clkctl_mode_reg #(.AUX_W(AUX_N)) u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .done      (done),
      .mode_now  (mode_now),
      .hiz       (out_hiz),
      .host_run  (host_run),
      .host_fast (host_fast),
      .test      (test_mode),
      .aux_run   (aux_run)
   );

   clkctl_pci_gate #(
      .NUM_PCI    (NUM_PCI),
      .STOP_COUNT (STOP_COUNT),
      .STOP_TOP   (STOP_TOP)
   ) u_pci (
      .clk         (clk),
      .rst_n       (rst_n),
      .allow       (done && mode_now.pci_allow),
      .hiz         (out_hiz),
      .bank_stop_n (bank_stop_n),
      .pci_en      (pci_en),
      .pci_clk     (pci_clk)
   );

   assign strap_valid = done;

endmodule

// File: rtl/clkctl_core_chk.sv
module clkctl_core_chk #(
   parameter int NUM_PCI = 8,
   parameter int STRAP_W = 2,
   parameter int AUX_W   = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [STRAP_W-1:0] mult_sel,
   input logic               strap_valid,
   input logic               out_hiz,
   input logic               host_run,
   input logic               host_fast,
   input logic               test_mode,
   input logic [AUX_W-1:0]   aux_run,
   input logic [NUM_PCI-1:0] pci_clk
);

   AST_PCI_SINGLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (pci_clk != '0) |=> ((pci_clk & $past(pci_clk)) == '0)); // R10

   AST_HIZ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      out_hiz |-> (!host_run && aux_run == '0 && pci_clk == '0)); // R7

   AST_EARLY_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      !strap_valid |-> out_hiz); // R3

   AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (strap_valid && $past(strap_valid)) |-> $stable(mult_sel)); // R2

   AST_TEST_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      test_mode |-> host_fast); // R5

endmodule

bind clkctl_core clkctl_core_chk #(
   .NUM_PCI (NUM_PCI),
   .STRAP_W (STRAP_W),
   .AUX_W   (clkctl_pkg::AUX_N)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mult_sel    (mult_sel),
   .strap_valid (strap_valid),
   .out_hiz     (out_hiz),
   .host_run    (host_run),
   .host_fast   (host_fast),
   .test_mode   (test_mode),
   .aux_run     (aux_run),
   .pci_clk     (pci_clk)
);

// File: tb/clkctl_core_bench.sv
`timescale 1ns/1ps
module clkctl_core_bench;

   localparam int NP = 6;
   localparam int SC = 4;
   localparam int SW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel_rate = 1'b0, sel_a = 1'b0, sel_b = 1'b0;
   logic          bank_stop_n = 1'b1;
   logic [NP-1:0] pci_en = '1;
   logic [SW-1:0] strap_in = 2'b10;
   logic [SW-1:0] mult_sel;
   logic          strap_valid, out_hiz, host_run, host_fast, test_mode;
   logic [2:0]    aux_run;
   logic [NP-1:0] pci_clk;

   int checks = 0;
   int failures = 0;
   bit finished = 0;
   string cur_req = "R3";

   always #4 clk = !clk;

   clkctl_core #(.NUM_PCI(NP), .STOP_COUNT(SC), .STOP_TOP(1'b1), .STRAP_W(SW)) u_clkctl_core (
      .clk(clk), .rst_n(rst_n), .sel_rate(sel_rate), .sel_a(sel_a), .sel_b(sel_b),
      .bank_stop_n(bank_stop_n), .pci_en(pci_en), .strap_in(strap_in),
      .mult_sel(mult_sel), .strap_valid(strap_valid), .out_hiz(out_hiz),
      .host_run(host_run), .host_fast(host_fast), .test_mode(test_mode),
      .aux_run(aux_run), .pci_clk(pci_clk)
   );

   // behavioural reference model, stepped once per rising edge
   bit          m_done, m_q, m_hiz, m_host, m_fast, m_test;
   bit [2:0]    m_aux;
   bit [NP-1:0] m_gate;
   bit [SW-1:0] m_mult;

   function automatic bit in_stop_group(int i);
      return i >= NP - SC;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_done = 0; m_q = 0; m_hiz = 1; m_host = 0; m_fast = 0; m_test = 0;
         m_aux = '0; m_gate = '0; m_mult = '0;
      end else begin
         int code;
         bit hz;
         code = {sel_rate, sel_a, sel_b};
         hz = (code == 3);
         if (m_q) begin
            for (int i = 0; i < NP; i++)
               m_gate[i] = m_done && !hz && pci_en[i] && !(in_stop_group(i) && !bank_stop_n);
         end
         m_q    = !m_q;
         m_hiz  = !m_done || hz;
         m_host = m_done && !hz;
         m_fast = m_done && (code == 4 || code == 7);
         m_test = m_done && (code == 7);
         m_aux  = (m_done && code != 1 && code != 3) ? 3'b111 : 3'b000;
         if (!m_done) begin
            m_mult = strap_in;
            m_done = 1;
         end
      end
   end

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison, away from the active edge
   bit [NP-1:0] prev_pci = '0;
   always @(negedge clk) begin
      if (!finished) begin
         bit [NP-1:0] exp_pci;
         for (int i = 0; i < NP; i++) exp_pci[i] = m_q && m_gate[i] && !m_hiz;
         check(cur_req, "strap_valid", strap_valid, m_done);
         check(cur_req, "mult_sel", mult_sel, m_mult);
         check(cur_req, "out_hiz", out_hiz, m_hiz);
         check(cur_req, "host_run", host_run, m_host);
         check(cur_req, "host_fast", host_fast, m_fast);
         check(cur_req, "test_mode", test_mode, m_test);
         check(cur_req, "aux_run", aux_run, m_aux);
         check(cur_req, "pci_clk", pci_clk, exp_pci);
         // R10: no output high on two consecutive samples
         check("R10", "pci_double_high", pci_clk & prev_pci, 0);
         prev_pci = pci_clk;
      end
   end

   task automatic set_code(bit [2:0] c);
      sel_rate = c[2]; sel_a = c[1]; sel_b = c[0];
   endtask

   task automatic wait_cycles(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #100000;
      failures++;
      $display("FAIL watchdog expired: actual=running expected=done");
      finish_run();
   end

   initial begin
      int highs;
      // R3: reset state
      wait_cycles(3);
      check("R3", "reset out_hiz", out_hiz, 1);
      check("R3", "reset pci_clk", pci_clk, 0);
      check("R3", "reset host_run", host_run, 0);
      rst_n = 1'b1;
      cur_req = "R2";
      wait_cycles(1);
      check("R2", "strap captured", mult_sel, 2'b10);
      check("R3", "hiz during capture cycle", out_hiz, 1);
      strap_in = 2'b01;  // R2: later pin activity must not reach mult_sel
      wait_cycles(3);
      check("R2", "strap held", mult_sel, 2'b10);

      cur_req = "R1";  // code 000, all enabled
      highs = 0;
      for (int k = 0; k < 20; k++) begin
         wait_cycles(1);
         if (pci_clk[0]) highs++;
      end
      check("R1", "pci0 high count in 20 cycles", highs, 10);

      cur_req = "R9";
      pci_en = 6'b101101;
      wait_cycles(6);
      check("R9", "disabled outputs low", pci_clk & ~6'b101101, 0);
      wait_cycles(14);

      cur_req = "R10";  // enable flipped every cycle
      for (int k = 0; k < 20; k++) begin
         pci_en = ~pci_en;
         wait_cycles(1);
      end
      pci_en = '1;
      wait_cycles(4);

      cur_req = "R4";
      set_code(3'b010);
      wait_cycles(2);
      check("R4", "reserved 010 aux_run", aux_run, 3'b111);
      set_code(3'b101); wait_cycles(6);
      set_code(3'b110); wait_cycles(6);
      set_code(3'b000); wait_cycles(6);

      cur_req = "R11";
      set_code(3'b100);
      wait_cycles(1);
      check("R11", "host_fast one edge after code", host_fast, 1);
      cur_req = "R5";
      wait_cycles(8);
      set_code(3'b111);
      wait_cycles(2);
      check("R5", "test_mode", test_mode, 1);
      wait_cycles(8);

      cur_req = "R6";
      set_code(3'b001);
      wait_cycles(3);
      check("R6", "aux held", aux_run, 0);
      check("R6", "host runs", host_run, 1);
      wait_cycles(8);

      cur_req = "R7";
      set_code(3'b011);
      wait_cycles(3);
      check("R7", "all hiz", out_hiz, 1);
      wait_cycles(8);
      set_code(3'b000);
      wait_cycles(6);

      cur_req = "R8";
      bank_stop_n = 1'b0;
      highs = 0;
      for (int k = 0; k < 20; k++) begin
         wait_cycles(1);
         if (k > 3 && (pci_clk & 6'b111100) != 0) highs++;
      end
      check("R8", "stop group high samples", highs, 0);
      bank_stop_n = 1'b1;
      wait_cycles(10);
      finish_run();
   end

endmodule